// File: doc/BRIEF.md
# Wiper Position Counter with Tap Decode

This block holds the position of one wiper on a 64-tap resistor ladder and turns that position into a one-hot enable, one bit for each tap switch. A design with two potentiometers instantiates it twice. The serial command layer drives it through plain single-cycle strobes. Those strobes can write a host value directly into the position. They can copy one of four stored data-register values into it. They can step it one tap up or down, taking the direction from the serial data level at that clock pulse. A power-up recall strobe reloads the position from data register 0.

The position register is volatile. After a recall it holds whatever data register 0 contains, which may differ from the value the position held before power was lost. A read-back byte gives the position in the form the serial layer shifts out to the host. If several strobes arrive in the same cycle, a fixed priority picks one. The tap enable vector is registered on the same edge as the position, so the switch selection moves in a single step and never shows two closed switches or none.

Top module: `wiper_ctr`

## Requirements
- R1: While reset is asserted, and on leaving reset, the position is 0 and the tap enable vector has only bit 0 set.
- R2: At every cycle the tap enable vector has exactly one bit set, and that bit is at the index equal to the current position, in the same cycle the position is shown.
- R3: A write strobe alone loads the write data into the position on the next clock edge.
- R4: A transfer strobe alone loads data register k into the position on the next edge, where k is the 2-bit select and register k occupies bits [6k+5:6k] of the data-register bus.
- R5: A recall strobe loads data register 0 (bus bits [5:0]) into the position on the next edge.
- R6: A step strobe alone moves the position by +1 when the direction input is 1 (toward the high terminal) and by -1 when it is 0 (toward the low terminal).
- R7: Stepping saturates. A step up at 63 leaves 63, and a step down at 0 leaves 0.
- R8: When strobes coincide, recall wins over transfer, transfer wins over write, and write wins over step.
- R9: The read-back byte has bits [7:6] zero and the position in bits [5:0].
- R10: In a cycle with no strobe asserted, the position and tap enables hold their values, whatever the data, select and direction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Power-up recall strobe: load from data register 0 |
| xfer_i | input | 1 | Transfer strobe: load from the selected data register |
| xfer_sel_i | input | 2 | Data register select for a transfer |
| dr_bank_i | input | 24 | Four 6-bit data registers; register k is at bits [6k+5:6k] |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | 6 | Host write value |
| step_i | input | 1 | Single-step strobe |
| step_up_i | input | 1 | Step direction: 1 is up, 0 is down |
| pos_o | output | 6 | Current wiper position |
| rd_byte_o | output | 8 | Read-back byte {2'b00, position} |
| tap_en_o | output | 64 | One-hot tap switch enables |

## Verification
The assertions take every strobe input to be 0 or 1 at each clock edge, never unknown. They take the data-register bus to be stable across the cycle in which it is sampled. The stimulus changes all inputs only on falling edges. It drives every strobe low in idle cycles. It keeps the bank value fixed while a recall or transfer is pending, so the value checked against is the value that was sampled.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // Load source picked for the next position, lowest to highest priority
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_STEP   = 3'd1,
    SRC_WRITE  = 3'd2,
    SRC_XFER   = 3'd3,
    SRC_RECALL = 3'd4
  } wpr_src_e;

endpackage

// File: rtl/wpr_src_arb.sv
module wpr_src_arb
  import wpr_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  parameter int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
  input  logic                    recall_i,
  input  logic                    xfer_i,
  input  logic [SEL_W-1:0]        xfer_sel_i,
  input  logic [NUM_DR*POS_W-1:0] dr_bank_i,
  input  logic                    wr_i,
  input  logic [POS_W-1:0]        wr_data_i,
  input  logic                    step_i,
  input  logic                    step_up_i,
  input  logic [POS_W-1:0]        cur_pos_i,
  output logic [POS_W-1:0]        nxt_pos_o,
  output wpr_src_e                src_o
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] dr_arr [NUM_DR];

  for (genvar k = 0; k < NUM_DR; k++) begin : g_unpack
    assign dr_arr[k] = dr_bank_i[k*POS_W +: POS_W];
  end

  logic [POS_W-1:0] dr_sel;
  always_comb begin
    dr_sel = dr_arr[0];
    for (int k = 0; k < NUM_DR; k++) begin
      if (SEL_W'(k) == xfer_sel_i) dr_sel = dr_arr[k];
    end
  end

  logic [POS_W-1:0] stepped;
  always_comb begin
    if (step_up_i) stepped = (cur_pos_i == POS_MAX) ? POS_MAX : cur_pos_i + 1'b1;
    else           stepped = (cur_pos_i == POS_MIN) ? POS_MIN : cur_pos_i - 1'b1;
  end

  always_comb begin
    if (recall_i)    src_o = SRC_RECALL;
    else if (xfer_i) src_o = SRC_XFER;
    else if (wr_i)   src_o = SRC_WRITE;
    else if (step_i) src_o = SRC_STEP;
    else             src_o = SRC_HOLD;
  end

  always_comb begin
    unique case (src_o)
      SRC_RECALL: nxt_pos_o = dr_arr[0];
      SRC_XFER:   nxt_pos_o = dr_sel;
      SRC_WRITE:  nxt_pos_o = wr_data_i;
      SRC_STEP:   nxt_pos_o = stepped;
      default:    nxt_pos_o = cur_pos_i;
    endcase
  end

endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
  parameter int POS_W = 6,
  parameter int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  tap_en_o
);

  logic [TAPS-1:0] dec;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign dec[t] = (pos_i == POS_W'(t));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tap_en_o <= TAPS'(1);
    else if (load_i) tap_en_o <= dec;
  end

  assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap_en_o));

endmodule

// File: rtl/wiper_ctr.sv
module wiper_ctr
  import wpr_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  parameter int TAPS   = 1 << POS_W,
  parameter int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recall_i,
  input  logic                    xfer_i,
  input  logic [SEL_W-1:0]        xfer_sel_i,
  input  logic [NUM_DR*POS_W-1:0] dr_bank_i,
  input  logic                    wr_i,
  input  logic [POS_W-1:0]        wr_data_i,
  input  logic                    step_i,
  input  logic                    step_up_i,
  output logic [POS_W-1:0]        pos_o,
  output logic [BYTE_W-1:0]       rd_byte_o,
  output logic [TAPS-1:0]         tap_en_o
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] nxt_pos;
  wpr_src_e         src;
  logic             load;

  wpr_src_arb #(.POS_W(POS_W), .NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_arb (
    .recall_i  (recall_i),
    .xfer_i    (xfer_i),
    .xfer_sel_i(xfer_sel_i),
    .dr_bank_i (dr_bank_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .step_i    (step_i),
    .step_up_i (step_up_i),
    .cur_pos_i (pos_q),
    .nxt_pos_o (nxt_pos),
    .src_o     (src)
  );

  assign load = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (load) pos_q <= nxt_pos;
  end

  wpr_tap_decode #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .pos_i   (nxt_pos),
    .tap_en_o(tap_en_o)
  );

  assign pos_o     = pos_q;
  assign rd_byte_o = {{(BYTE_W-POS_W){1'b0}}, pos_q};

  // R2: the decoded enable matches the held position
  assert_tap_matches_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en_o[pos_q] == 1'b1);

  assert_recall_loads_dr0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recall_i |=> pos_q == $past(dr_bank_i[POS_W-1:0]));

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !recall_i && !xfer_i) |=> pos_q == $past(wr_data_i));

  assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && step_up_i && !recall_i && !xfer_i && !wr_i && pos_q == POS_MAX)
      |=> pos_q == POS_MAX);

  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !step_up_i && !recall_i && !xfer_i && !wr_i && pos_q == '0)
      |=> pos_q == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !recall_i && !xfer_i && !wr_i) |=> ($stable(pos_q) && $stable(tap_en_o)));

endmodule

// File: tb/tb_wiper_ctr.sv
module tb_wiper_ctr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        recall_i = 1'b0, xfer_i = 1'b0, wr_i = 1'b0, step_i = 1'b0, step_up_i = 1'b0;
  logic [1:0]  xfer_sel_i = '0;
  logic [23:0] dr_bank_i;
  logic [5:0]  wr_data_i = '0;
  logic [5:0]  pos_o;
  logic [7:0]  rd_byte_o;
  logic [63:0] tap_en_o;

  int checks = 0;
  int failures = 0;
  logic [5:0] model_pos = '0;
  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  wiper_ctr dut (
    .clk(clk), .rst_n(rst_n), .recall_i(recall_i), .xfer_i(xfer_i),
    .xfer_sel_i(xfer_sel_i), .dr_bank_i(dr_bank_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .step_i(step_i), .step_up_i(step_up_i),
    .pos_o(pos_o), .rd_byte_o(rd_byte_o), .tap_en_o(tap_en_o)
  );

  function automatic logic [5:0] bank(input int k);
    return dr_bank_i[k*6 +: 6];
  endfunction

  task automatic compare(input logic [5:0] e, input string tag);
    checks++;
    if (pos_o !== e || tap_en_o !== (64'd1 << e) || rd_byte_o !== {2'b00, e}) begin
      failures++;
      $display("FAIL %s: pos=%0d tap=%h byte=%h expected pos=%0d tap=%h byte=%h",
               tag, pos_o, tap_en_o, rd_byte_o, e, 64'd1 << e, {2'b00, e});
    end
  endtask

  // Driver: apply one cycle of strobes and push the expected position
  task automatic do_op(input logic rc, input logic xf, input logic [1:0] sel,
                       input logic w, input logic [5:0] d, input logic st,
                       input logic up, input string tag);
    @(negedge clk);
    recall_i = rc; xfer_i = xf; xfer_sel_i = sel; wr_i = w; wr_data_i = d;
    step_i = st; step_up_i = up;
    if (rc)      model_pos = bank(0);
    else if (xf) model_pos = bank(int'(sel));
    else if (w)  model_pos = d;
    else if (st) begin
      if (up) model_pos = (model_pos == 6'd63) ? 6'd63 : model_pos + 6'd1;
      else    model_pos = (model_pos == 6'd0)  ? 6'd0  : model_pos - 6'd1;
    end
    exp_q.push_back(model_pos);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dr_bank_i = {6'd42, 6'd0, 6'd63, 6'd21};
    #20;
    compare(6'd0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare(6'd0, "R1 after reset");
    do_op(0,0,0,0,6'd33,0,1, "R10 idle with data");
    do_op(0,0,0,1,6'd5,0,0,  "R3 write 5");
    do_op(0,0,0,0,0,1,1,     "R6 step up");
    do_op(0,0,0,0,0,1,0,     "R6 step down");
    do_op(0,0,0,1,6'd62,0,0, "R3 write 62");
    do_op(0,0,0,0,0,1,1,     "R6 step to 63");
    do_op(0,0,0,0,0,1,1,     "R7 saturate top");
    do_op(0,0,0,1,6'd1,0,0,  "R3 write 1");
    do_op(0,0,0,0,0,1,0,     "R6 step to 0");
    do_op(0,0,0,0,0,1,0,     "R7 saturate bottom");
    do_op(0,1,2'd3,0,0,0,0,  "R4 xfer reg3");
    do_op(0,1,2'd1,0,0,0,0,  "R4 xfer reg1");
    do_op(0,1,2'd2,0,0,0,0,  "R4 xfer reg2");
    do_op(1,0,0,0,0,0,0,     "R5 recall");
    do_op(0,0,0,1,6'd10,0,0, "R3 write 10");
    do_op(1,1,2'd3,1,6'd9,1,1, "R8 recall wins");
    do_op(0,1,2'd3,1,6'd9,1,0, "R8 xfer wins");
    do_op(0,0,0,1,6'd7,1,1,  "R8 write wins");
    do_op(0,0,2'd1,0,6'd50,0,0, "R10 idle hold");
    for (int i = 0; i < 4; i++) do_op(0,0,0,0,0,1,1, "R2 step walk");
    for (int i = 0; i < 3; i++) do_op(0,0,0,0,0,1,0, "R9 step walk");
    do_op(0,0,0,0,0,0,0, "R10 final idle");
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule